// File: doc/BRIEF.md
# Reduced Four-State Mealy Sequence Machine

This block is a small synchronous Mealy machine that reads one bit `x` per clock and drives a one-bit answer `z`. The answer depends on the present state and on the `x` of the same cycle. It reproduces, cycle for cycle, a seven-state transition table after that table has been minimised. In the minimised form, the two states that behave identically are merged into a single state, called CE here. The pair of states that can never be entered from the initial state is removed. Four states remain, and they fit in a 2-bit register.

The state register is built as two set/clear cells, in the manner of RS flip-flops. A control module computes the next state and the output. It then converts each bit change into a set strobe or a clear strobe and passes those strobes to the register in a small struct. A synchronous reset returns the machine to its initial state A.

State codes, which the bench observes only through `z`: A = 2'b00, B = 2'b01, CE = 2'b10, D = 2'b11.

Top module: `mealy_min4`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the state becomes A (code 2'b00), whatever the present state and whatever `x` is.
- R2: In state A, `x`=1 gives `z`=1 and the machine stays in A. `x`=0 gives `z`=0 and the machine moves to B.
- R3: In state B, `x`=0 gives `z`=1 and the machine moves to CE. `x`=1 gives `z`=0 and the machine moves to D.
- R4: In state CE, `z`=1 for both values of `x`, and the machine stays in CE until a reset.
- R5: In state D, `x`=1 gives `z`=0 and the machine stays in D. `x`=0 gives `z`=1 and the machine returns to A.
- R6: `z` is a combinational function of the registered state and the current `x`. A change of `x` inside a cycle changes `z` in that same cycle, and the state changes only at a rising edge of `clk`.
- R7: Started from A, the sequence of `z` values equals the output sequence of the original seven-state table for every input sequence.
- R8: The set strobe and the clear strobe of any state bit are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, returns the machine to state A |
| x | input | 1 | Serial input bit |
| z | output | 1 | Mealy output for the present state and `x` |

## Verification
On every cycle, the assertions check each of the four state transitions and their output values, the return to A after reset, the absorbing behaviour of CE, and the rule that no state bit receives a set strobe and a clear strobe together. These checks observe the internal state code.

The bench sees only `z`. Its scenarios therefore show the state through output patterns:
- Flipping `x` within a single cycle shows that `z` follows `x` in that cycle.
- A reset applied from inside CE shows that the machine returns to A.
- Many short random sequences, each started from reset, are compared against a behavioural model of the full seven-state table. This comparison exercises the merge of the two equivalent states, which no single-cycle property can show.

// File: rtl/mm4_pkg.sv
package mm4_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_A  = 2'b00,
    ST_B  = 2'b01,
    ST_CE = 2'b10,
    ST_D  = 2'b11
  } state_t;

  localparam state_t RESET_STATE = ST_A;

  // Per-bit set/clear requests from control to the state register.
  typedef struct packed {
    logic [STATE_W-1:0] setBits;
    logic [STATE_W-1:0] clrBits;
  } rsStrobe_t;
endpackage

// File: rtl/mm4_state_reg.sv
module mm4_state_reg
  import mm4_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rsStrobe_t strobe,
  output state_t    curState
);
  localparam logic [STATE_W-1:0] RST_CODE = RESET_STATE;

  logic [STATE_W-1:0] qBits;

  // Each bit behaves like a clocked set/reset cell; set wins only by
  // convention, the controller never raises both.
  always_ff @(posedge clk) begin
    for (int i = 0; i < STATE_W; i++) begin
      if (rst)                    qBits[i] <= RST_CODE[i];
      else if (strobe.setBits[i]) qBits[i] <= 1'b1;
      else if (strobe.clrBits[i]) qBits[i] <= 1'b0;
    end
  end

  assign curState = state_t'(qBits);
endmodule

// File: rtl/mm4_ctrl.sv
module mm4_ctrl
  import mm4_pkg::*;
(
  input  state_t    curState,
  input  logic      x,
  output rsStrobe_t strobe,
  output logic      z
);
  state_t nextState;

  always_comb begin
    nextState = curState;
    z         = 1'b1;
    unique case (curState)
      ST_A: begin
        nextState = x ? ST_A : ST_B;
        z         = x;
      end
      ST_B: begin
        nextState = x ? ST_D : ST_CE;
        z         = ~x;
      end
      ST_CE: begin
        nextState = ST_CE;
        z         = 1'b1;
      end
      ST_D: begin
        nextState = x ? ST_D : ST_A;
        z         = ~x;
      end
      default: begin
        nextState = RESET_STATE;
        z         = 1'b0;
      end
    endcase
  end

  // RS excitation: set a bit that must rise, clear a bit that must fall.
  always_comb begin
    strobe.setBits = nextState & ~curState;
    strobe.clrBits = ~nextState & curState;
  end
endmodule

// File: rtl/mealy_min4.sv
module mealy_min4
  import mm4_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  state_t    curState;
  rsStrobe_t strobe;

  mm4_ctrl u_ctrl (
    .curState (curState),
    .x        (x),
    .strobe   (strobe),
    .z        (z)
  );

  mm4_state_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState)
  );
endmodule

// File: rtl/mm4_checker.sv
module mm4_checker
  import mm4_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      x,
  input logic      z,
  input state_t    curState,
  input rsStrobe_t strobe
);
  AST_RESET_TO_A: assert property (@(posedge clk) rst |=> curState == ST_A); // R1
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst) (curState == ST_A && x) |=> curState == ST_A); // R2
  AST_A_TO_B: assert property (@(posedge clk) disable iff (rst) (curState == ST_A && !x) |=> curState == ST_B); // R2
  AST_A_OUT: assert property (@(posedge clk) disable iff (rst) (curState == ST_A) |-> z == x); // R2
  AST_B_TO_CE: assert property (@(posedge clk) disable iff (rst) (curState == ST_B && !x) |=> curState == ST_CE); // R3
  AST_B_TO_D: assert property (@(posedge clk) disable iff (rst) (curState == ST_B && x) |=> curState == ST_D); // R3
  AST_B_OUT: assert property (@(posedge clk) disable iff (rst) (curState == ST_B) |-> z == !x); // R3
  AST_CE_SINK: assert property (@(posedge clk) disable iff (rst) (curState == ST_CE) |=> curState == ST_CE); // R4
  AST_CE_OUT: assert property (@(posedge clk) disable iff (rst) (curState == ST_CE) |-> z); // R4
  AST_D_HOLD: assert property (@(posedge clk) disable iff (rst) (curState == ST_D && x) |=> curState == ST_D); // R5
  AST_D_TO_A: assert property (@(posedge clk) disable iff (rst) (curState == ST_D && !x) |=> curState == ST_A); // R5
  AST_D_OUT: assert property (@(posedge clk) disable iff (rst) (curState == ST_D) |-> z == !x); // R5
  AST_RS_EXCL: assert property (@(posedge clk) disable iff (rst) (strobe.setBits & strobe.clrBits) == '0); // R8
endmodule

bind mealy_min4 mm4_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .x        (x),
  .z        (z),
  .curState (curState),
  .strobe   (strobe)
);

// File: tb/sim_mealy_min4.sv
`timescale 1ns/1ps
module sim_mealy_min4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;

  int nCompared   = 0;
  int nMismatched = 0;
  bit finished    = 1'b0;

  // Behavioural model of the seven-state table: 0..6 = A..G.
  int modelState = 0;

  always #5 clk = ~clk;

  mealy_min4 u0 (.clk(clk), .rst(rst), .x(x), .z(z));

  function automatic int modelNext(int s, logic xv);
    case (s)
      0: return xv ? 0 : 1;
      1: return xv ? 3 : 2;
      2: return xv ? 2 : 4;
      3: return xv ? 3 : 0;
      4: return xv ? 2 : 4;
      5: return xv ? 6 : 5;
      default: return xv ? 5 : 6;
    endcase
  endfunction

  function automatic logic modelOut(int s, logic xv);
    case (s)
      0: return xv;
      1: return ~xv;
      2: return 1'b1;
      3: return ~xv;
      4: return 1'b1;
      5: return xv;
      default: return ~xv;
    endcase
  endfunction

  task automatic check(logic got, logic exp, string tag);
    nCompared++;
    if (got !== exp) begin
      nMismatched++;
      $display("FAIL %s: z=%b expected %b", tag, got, exp);
    end
  endtask

  // Inputs change after the falling edge; z sampled 1 ns later.
  task automatic stepBit(logic xv, string tag);
    x = xv;
    #1;
    check(z, modelOut(modelState, xv), tag);
    @(posedge clk);
    modelState = modelNext(modelState, xv);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    modelState = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    x = 1'b0; #1; check(z, 1'b0, "R1 reset state x=0");
    x = 1'b1; #1; check(z, 1'b1, "R1 reset state x=1");
    @(negedge clk);
  endtask

  task automatic testStateA();
    doReset();
    stepBit(1'b1, "R2 A x=1");
    stepBit(1'b1, "R2 A stays A");
    stepBit(1'b0, "R2 A x=0");
    stepBit(1'b1, "R2 now in B (z=0)");
  endtask

  task automatic testStateB();
    doReset();
    stepBit(1'b0, "R3 to B");
    stepBit(1'b0, "R3 B x=0");
    stepBit(1'b0, "R3 now CE x=0");
    doReset();
    stepBit(1'b0, "R3 to B");
    stepBit(1'b1, "R3 B x=1");
    stepBit(1'b1, "R3 now D x=1");
  endtask

  task automatic testSink();
    doReset();
    stepBit(1'b0, "R4 to B");
    stepBit(1'b0, "R4 to CE");
    for (int i = 0; i < 12; i++) stepBit(logic'(i % 3 == 0), "R4 CE absorbs");
  endtask

  task automatic testStateD();
    doReset();
    stepBit(1'b0, "R5 to B");
    stepBit(1'b1, "R5 to D");
    stepBit(1'b1, "R5 D x=1");
    stepBit(1'b0, "R5 D x=0");
    stepBit(1'b1, "R5 back in A (z=1)");
    stepBit(1'b0, "R5 A x=0 (z=0)");
  endtask

  task automatic testMealyTiming();
    doReset();
    stepBit(1'b0, "R6 to B");
    x = 1'b0; #1; check(z, 1'b1, "R6 B same-cycle x=0");
    x = 1'b1; #1; check(z, 1'b0, "R6 B same-cycle x=1");
    x = 1'b0; #1; check(z, 1'b1, "R6 B same-cycle x=0 again");
    @(posedge clk); modelState = modelNext(modelState, 1'b0);
    @(negedge clk);
    x = 1'b1; #1; check(z, 1'b1, "R6 in CE after edge");
    @(negedge clk);
    rst = 1'b1; x = 1'b0;
    #1; check(z, 1'b1, "R6 rst not yet clocked, still CE");
    @(posedge clk); modelState = 0;
    @(negedge clk); rst = 1'b0;
    #1; check(z, 1'b0, "R1 reset from CE gives A");
    @(negedge clk);
  endtask

  task automatic testRandom();
    logic [31:0] lfsr = 32'h1D2C_3B4A;
    for (int seg = 0; seg < 300; seg++) begin
      doReset();
      for (int k = 0; k < 8; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        stepBit(lfsr[0], "R7 random vs seven-state model");
      end
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testStateA();
    testStateB();
    testSink();
    testStateD();
    testMealyTiming();
    testRandom();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end
endmodule